// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate with Half-Word Write-Back

This block holds two independent multiply-accumulate lanes that run side by side. In each cycle a lane is enabled, it multiplies two 16-bit operands and then does one of three things with its 40-bit accumulator: loads the product, adds the product, or subtracts the product. A fourth operation code keeps the accumulator as it is. After the update, the lane reduces the new accumulator to one saturated 16-bit value and writes it into its own half of a shared 32-bit destination word. Lane 0 owns the low half and lane 1 owns the high half.

A single set of mode inputs is shared by both lanes during a cycle. It selects:
- the operand and extract interpretation: fractional or integer, and signed or unsigned;
- truncation instead of rounding;
- doubling of the accumulator before it is reduced;
- a mixed-signedness product, which only lane 1 honours.

A separate rounding-mode input chooses between round-half-up and round-half-to-even for every fractional extract that rounds. Each lane also keeps a sticky overflow flag. The flag is set when the accumulator or the 16-bit extract saturates.

Every result appears on the outputs one clock edge after the enabled cycle. There is no other latency.

Top module: `dual_mac_half`

## Requirements
- R1: Synchronous active-high reset clears both accumulators, the destination word and both overflow flags to zero.
- R2: Operation code 2'b00 loads the product into the accumulator. 2'b01 adds the product. 2'b10 subtracts the product. 2'b11 leaves the accumulator unchanged and writes the extract of its current value.
- R3: When a lane's enable bit is low, that lane's accumulator, destination half and overflow flag keep their values.
- R4: With `m_uns` high both operands are unsigned. Otherwise both are signed. With `m_mixed` high and `m_uns` low, lane 1 treats operand a as signed and operand b as unsigned. Lane 0 ignores `m_mixed`.
- R5: In signed fractional mode (`m_int`=0, `m_uns`=0, no mixed product) the product is doubled. 0x8000 times 0x8000 gives 0x7FFFFFFF instead.
- R6: An accumulator result outside the 40-bit signed range is clamped to 0x7FFFFFFFFF or 0x8000000000, and the lane's overflow flag is set.
- R7: A fractional extract (`m_int`=0) takes accumulator bits [31:16]. If `m_trunc` is high, the low 16 bits are discarded. Otherwise the value is rounded on those bits: a tie rounds up when `rnd_even`=0 and rounds to the even result when `rnd_even`=1.
- R8: An integer extract (`m_int`=1) takes the accumulator value itself, with no rounding.
- R9: The extract is clamped to [-32768, 32767], or to [0, 65535] when `m_uns` is high. Clamping sets the lane's overflow flag.
- R10: With `m_dbl` high the accumulator value is doubled before rounding or clamping. The stored accumulator is not doubled.
- R11: Lane 0 writes `dst[15:0]` and drives `acc0`. Lane 1 writes `dst[31:16]` and drives `acc1`.
- R12: An overflow flag stays set until reset.
- R13: An enabled operation's results appear after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 2 | Per-lane enable; bit 0 is lane 0 |
| l0_a | input | 16 | Lane 0 operand a |
| l0_b | input | 16 | Lane 0 operand b |
| l0_op | input | 2 | Lane 0 operation code |
| l1_a | input | 16 | Lane 1 operand a |
| l1_b | input | 16 | Lane 1 operand b |
| l1_op | input | 2 | Lane 1 operation code |
| m_int | input | 1 | Integer mode (1) or fractional mode (0) |
| m_uns | input | 1 | Unsigned operands and unsigned extract clamp |
| m_trunc | input | 1 | Truncate instead of round in fractional mode |
| m_dbl | input | 1 | Double the accumulator before extraction |
| m_mixed | input | 1 | Signed a times unsigned b, lane 1 only |
| rnd_even | input | 1 | Tie rounding: 0 rounds up, 1 rounds to even |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |
| dst | output | 32 | Destination word built from both lane extracts |
| ovf | output | 2 | Sticky overflow flags; bit 0 is lane 0 |

## Verification
The assertions cover the rules that hold in every cycle:
- a disabled lane keeps its accumulator, destination half and flag;
- the keep operation leaves the accumulator alone;
- an overflow flag never falls outside reset;
- reset clears a lane.

The arithmetic can only be shown by the directed scenarios, each with hand-computed values:
- tie rounding in both rounding modes, including negative values;
- the 0x8000 squared special case;
- lane 1 honouring the mixed product while lane 0 ignores it;
- doubling;
- 16-bit and 40-bit clamping, and where each lane lands in the destination word.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    parameter int OPW    = 16;
    parameter int GUARD  = 8;
    parameter int NLANES = 2;

    localparam int PRODW = 2*OPW + 2;
    localparam int ACCW  = 2*OPW + GUARD;
    localparam int EXTW  = ACCW + 2;
    localparam int DSTW  = NLANES*OPW;

    localparam logic signed [EXTW-1:0] HS_MAX = EXTW'(2**(OPW-1) - 1);
    localparam logic signed [EXTW-1:0] HS_MIN = ~HS_MAX;
    localparam logic signed [EXTW-1:0] HU_MAX = EXTW'(2**OPW - 1);

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_KEEP = 2'b11
    } mac_op_e;

    typedef struct packed {
        logic int_mode;
        logic uns;
        logic trunc;
        logic dbl;
        logic rnd_even;
    } mac_mode_t;

    typedef struct packed {
        logic [ACCW-1:0] acc;
        logic            sat;
    } acc_res_t;

    typedef struct packed {
        logic [OPW-1:0] val;
        logic           sat;
    } half_res_t;

    // Clamp a one-bit-wider sum to the accumulator range.
    function automatic acc_res_t acc_clip(input logic signed [ACCW:0] s);
        acc_res_t r;
        r.sat = s[ACCW] ^ s[ACCW-1];
        if (!r.sat)
            r.acc = s[ACCW-1:0];
        else if (s[ACCW])
            r.acc = {1'b1, {(ACCW-1){1'b0}}};
        else
            r.acc = {1'b0, {(ACCW-1){1'b1}}};
        return r;
    endfunction

    // Clamp a wide signed value to a signed or unsigned half-word.
    function automatic half_res_t half_clip(input logic signed [EXTW-1:0] v,
                                            input logic uns);
        half_res_t r;
        r.sat = 1'b0;
        r.val = v[OPW-1:0];
        if (uns) begin
            if (v[EXTW-1]) begin
                r.sat = 1'b1;
                r.val = '0;
            end else if (v > HU_MAX) begin
                r.sat = 1'b1;
                r.val = '1;
            end
        end else begin
            if (v > HS_MAX) begin
                r.sat = 1'b1;
                r.val = HS_MAX[OPW-1:0];
            end else if (v < HS_MIN) begin
                r.sat = 1'b1;
                r.val = HS_MIN[OPW-1:0];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dmac_mult.sv
module dmac_mult
    import dmac_pkg::*;
(
    input  logic [OPW-1:0]          a,
    input  logic [OPW-1:0]          b,
    input  logic                    int_mode,
    input  logic                    uns,
    input  logic                    mix_en,
    output logic signed [PRODW-1:0] prod
);

    localparam logic [OPW-1:0] MIN_OP = {1'b1, {(OPW-1){1'b0}}};
    localparam logic signed [PRODW-1:0] PROD_TOP =
        {{(PRODW-2*OPW+1){1'b0}}, {(2*OPW-1){1'b1}}};

    logic                    b_uns;
    logic                    dbl_prod;
    logic signed [OPW:0]     ax;
    logic signed [OPW:0]     bx;
    logic signed [PRODW-1:0] raw;

    always_comb begin
        b_uns    = uns | mix_en;
        dbl_prod = !int_mode && !uns && !mix_en;
        ax       = uns   ? {1'b0, a} : {a[OPW-1], a};
        bx       = b_uns ? {1'b0, b} : {b[OPW-1], b};
        raw      = PRODW'(ax) * PRODW'(bx);
        if (dbl_prod && a == MIN_OP && b == MIN_OP)
            prod = PROD_TOP;
        else if (dbl_prod)
            prod = raw <<< 1;
        else
            prod = raw;
    end

endmodule

// File: rtl/dmac_extract.sv
module dmac_extract
    import dmac_pkg::*;
(
    input  logic [ACCW-1:0] acc,
    input  mac_mode_t       mode,
    output logic [OPW-1:0]  half,
    output logic            sat
);

    localparam logic [OPW-1:0] TIE = {1'b1, {(OPW-1){1'b0}}};

    logic signed [EXTW-1:0] x;
    logic signed [EXTW-1:0] t;
    logic signed [EXTW-1:0] q;
    logic [OPW-1:0]         low;
    logic                   tie;
    logic                   inc;
    half_res_t              hr;

    always_comb begin
        x = {{2{acc[ACCW-1]}}, acc};
        if (mode.dbl)
            x = x <<< 1;
        t   = x >>> OPW;
        low = x[OPW-1:0];
        tie = (low == TIE);
        if (mode.trunc)
            inc = 1'b0;
        else if (mode.rnd_even)
            inc = (low[OPW-1] && !tie) || (tie && t[0]);
        else
            inc = low[OPW-1];
        if (mode.int_mode)
            q = x;
        else
            q = t + {{(EXTW-1){1'b0}}, inc};
        hr   = half_clip(q, mode.uns);
        half = hr.val;
        sat  = hr.sat;
    end

endmodule

// File: rtl/dmac_lane.sv
module dmac_lane
    import dmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [OPW-1:0]  a,
    input  logic [OPW-1:0]  b,
    input  mac_op_e         op,
    input  mac_mode_t       mode,
    input  logic            mix_en,
    output logic [ACCW-1:0] acc_o,
    output logic [OPW-1:0]  half_o,
    output logic            ovf_o
);

    logic signed [PRODW-1:0] prod;
    logic signed [ACCW:0]    p_ext;
    logic signed [ACCW:0]    cur_ext;
    logic signed [ACCW:0]    sum;
    acc_res_t                res;
    logic [OPW-1:0]          half_nxt;
    logic                    half_sat;
    logic [ACCW-1:0]         acc_q;
    logic [OPW-1:0]          half_q;
    logic                    ovf_q;

    dmac_mult u_mult (
        .a        (a),
        .b        (b),
        .int_mode (mode.int_mode),
        .uns      (mode.uns),
        .mix_en   (mix_en),
        .prod     (prod)
    );

    always_comb begin
        p_ext   = {{(ACCW+1-PRODW){prod[PRODW-1]}}, prod};
        cur_ext = {acc_q[ACCW-1], acc_q};
        unique case (op)
            OP_LOAD: sum = p_ext;
            OP_ADD:  sum = cur_ext + p_ext;
            OP_SUB:  sum = cur_ext - p_ext;
            default: sum = cur_ext;
        endcase
        res = acc_clip(sum);
    end

    dmac_extract u_extract (
        .acc  (res.acc),
        .mode (mode),
        .half (half_nxt),
        .sat  (half_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            half_q <= '0;
            ovf_q  <= 1'b0;
        end else if (en) begin
            acc_q  <= res.acc;
            half_q <= half_nxt;
            ovf_q  <= ovf_q | res.sat | half_sat;
        end
    end

    assign acc_o  = acc_q;
    assign half_o = half_q;
    assign ovf_o  = ovf_q;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && half_q == '0 && !ovf_q));

    a_r3_idle_lane_holds: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc_q) && $stable(half_q) && $stable(ovf_q)));

    a_r2_keep_op: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_KEEP) |=> $stable(acc_q));

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/dual_mac_half.sv
module dual_mac_half
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLANES-1:0] lane_en,
    input  logic [OPW-1:0]    l0_a,
    input  logic [OPW-1:0]    l0_b,
    input  logic [1:0]        l0_op,
    input  logic [OPW-1:0]    l1_a,
    input  logic [OPW-1:0]    l1_b,
    input  logic [1:0]        l1_op,
    input  logic              m_int,
    input  logic              m_uns,
    input  logic              m_trunc,
    input  logic              m_dbl,
    input  logic              m_mixed,
    input  logic              rnd_even,
    output logic [ACCW-1:0]   acc0,
    output logic [ACCW-1:0]   acc1,
    output logic [DSTW-1:0]   dst,
    output logic [NLANES-1:0] ovf
);

    mac_mode_t         mode;
    logic [OPW-1:0]    a_v    [NLANES];
    logic [OPW-1:0]    b_v    [NLANES];
    logic [1:0]        op_v   [NLANES];
    logic [ACCW-1:0]   acc_v  [NLANES];
    logic [OPW-1:0]    half_v [NLANES];
    logic [NLANES-1:0] mix_sel;

    assign mode = '{int_mode: m_int, uns: m_uns, trunc: m_trunc,
                    dbl: m_dbl, rnd_even: rnd_even};

    assign a_v[0]  = l0_a;
    assign b_v[0]  = l0_b;
    assign op_v[0] = l0_op;
    assign a_v[1]  = l1_a;
    assign b_v[1]  = l1_b;
    assign op_v[1] = l1_op;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        // Only the top lane may form a mixed-signedness product.
        if (g == NLANES-1) begin : g_mix
            assign mix_sel[g] = m_mixed & ~m_uns;
        end else begin : g_plain
            assign mix_sel[g] = 1'b0;
        end

        dmac_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (lane_en[g]),
            .a      (a_v[g]),
            .b      (b_v[g]),
            .op     (mac_op_e'(op_v[g])),
            .mode   (mode),
            .mix_en (mix_sel[g]),
            .acc_o  (acc_v[g]),
            .half_o (half_v[g]),
            .ovf_o  (ovf[g])
        );

        assign dst[g*OPW +: OPW] = half_v[g];
    end

    assign acc0 = acc_v[0];
    assign acc1 = acc_v[1];

endmodule

// File: tb/tb_dual_mac_half.sv
`timescale 1ns/1ps
module tb_dual_mac_half;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  lane_en = 2'b00;
    logic [15:0] l0_a = '0, l0_b = '0, l1_a = '0, l1_b = '0;
    logic [1:0]  l0_op = '0, l1_op = '0;
    logic        m_int = 0, m_uns = 0, m_trunc = 0, m_dbl = 0, m_mixed = 0, rnd_even = 0;
    logic [39:0] acc0, acc1;
    logic [31:0] dst;
    logic [1:0]  ovf;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dual_mac_half dut (
        .clk(clk), .rst(rst), .lane_en(lane_en),
        .l0_a(l0_a), .l0_b(l0_b), .l0_op(l0_op),
        .l1_a(l1_a), .l1_b(l1_b), .l1_op(l1_op),
        .m_int(m_int), .m_uns(m_uns), .m_trunc(m_trunc), .m_dbl(m_dbl),
        .m_mixed(m_mixed), .rnd_even(rnd_even),
        .acc0(acc0), .acc1(acc1), .dst(dst), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mode_set(input logic i, input logic u, input logic t,
                            input logic d, input logic m, input logic e);
        m_int = i; m_uns = u; m_trunc = t; m_dbl = d; m_mixed = m; rnd_even = e;
    endtask

    task automatic fire(input logic [1:0] en,
                        input logic [15:0] a0, input logic [15:0] b0, input logic [1:0] o0,
                        input logic [15:0] a1, input logic [15:0] b1, input logic [1:0] o1);
        lane_en = en;
        l0_a = a0; l0_b = b0; l0_op = o0;
        l1_a = a1; l1_b = b1; l1_op = o1;
        @(posedge clk);
        #1;
        lane_en = 2'b00;
    endtask

    task automatic t_reset();
        chk("R1 acc0 after reset", acc0, 40'h0);
        chk("R1 acc1 after reset", acc1, 40'h0);
        chk("R1 dst after reset", {8'h0, dst}, 40'h0);
        chk("R1 ovf after reset", {38'h0, ovf}, 40'h0);
    endtask

    task automatic t_frac_special();
        mode_set(0, 0, 1, 0, 0, 0);
        lane_en = 2'b11;
        l0_a = 16'h4000; l0_b = 16'h4000; l0_op = 2'b00;
        l1_a = 16'h8000; l1_b = 16'h8000; l1_op = 2'b00;
        #2;
        chk("R13 dst unchanged before edge", {8'h0, dst}, 40'h0);
        fire(2'b11, 16'h4000, 16'h4000, 2'b00, 16'h8000, 16'h8000, 2'b00);
        chk("R5 doubled product acc0", acc0, 40'h0020000000);
        chk("R5 min times min acc1", acc1, 40'h007FFFFFFF);
        chk("R11 R7 halves placed in dst", {8'h0, dst}, 40'h7FFF2000);
        chk("R5 no overflow", {38'h0, ovf}, 40'h0);
    endtask

    task automatic t_ops();
        mode_set(0, 0, 0, 0, 0, 0);
        fire(2'b01, 16'h0100, 16'h0100, 2'b00, 16'h1234, 16'h1234, 2'b00);
        chk("R2 load acc0", acc0, 40'h20000);
        chk("R2 load extract", {24'h0, dst[15:0]}, 40'h2);
        fire(2'b01, 16'h0100, 16'h0100, 2'b01, 16'h1234, 16'h1234, 2'b00);
        chk("R2 add acc0", acc0, 40'h40000);
        fire(2'b01, 16'h0080, 16'h0100, 2'b10, 16'h1234, 16'h1234, 2'b00);
        chk("R2 sub acc0", acc0, 40'h30000);
        chk("R2 sub extract", {24'h0, dst[15:0]}, 40'h3);
        fire(2'b01, 16'h7FFF, 16'h7FFF, 2'b11, 16'h1234, 16'h1234, 2'b00);
        chk("R2 keep acc0", acc0, 40'h30000);
        chk("R2 keep extract", {24'h0, dst[15:0]}, 40'h3);
        chk("R3 idle lane1 acc", acc1, 40'h007FFFFFFF);
        chk("R3 idle lane1 half", {24'h0, dst[31:16]}, 40'h7FFF);
    endtask

    task automatic t_round();
        mode_set(0, 0, 0, 0, 0, 0);
        fire(2'b01, 16'h0100, 16'h0140, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 acc for tie", acc0, 40'h28000);
        chk("R7 tie biased rounds up", {24'h0, dst[15:0]}, 40'h3);
        mode_set(0, 0, 0, 0, 0, 1);
        fire(2'b01, 16'h0100, 16'h0140, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 tie to even stays 2", {24'h0, dst[15:0]}, 40'h2);
        fire(2'b01, 16'h0100, 16'h00C0, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 tie to even goes 1 to 2", {24'h0, dst[15:0]}, 40'h2);
        mode_set(0, 0, 1, 0, 0, 0);
        fire(2'b01, 16'h0100, 16'h0140, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 truncate drops tie", {24'h0, dst[15:0]}, 40'h2);
        mode_set(0, 0, 0, 0, 0, 0);
        fire(2'b01, 16'hFF00, 16'h0140, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 negative acc", acc0, 40'hFFFFFD8000);
        chk("R7 negative tie biased", {24'h0, dst[15:0]}, 40'hFFFE);
        mode_set(0, 0, 0, 0, 0, 1);
        fire(2'b01, 16'hFF00, 16'h0140, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 negative tie to even", {24'h0, dst[15:0]}, 40'hFFFE);
        mode_set(0, 0, 1, 0, 0, 0);
        fire(2'b01, 16'hFF00, 16'h0140, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R7 negative truncate", {24'h0, dst[15:0]}, 40'hFFFD);
    endtask

    task automatic t_int();
        mode_set(1, 0, 0, 0, 0, 0);
        fire(2'b01, 16'h0003, 16'h0005, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R8 integer acc", acc0, 40'hF);
        chk("R8 integer extract", {24'h0, dst[15:0]}, 40'hF);
        fire(2'b01, 16'hFFFD, 16'h0005, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R8 negative integer acc", acc0, 40'hFFFFFFFFF1);
        chk("R8 negative integer extract", {24'h0, dst[15:0]}, 40'hFFF1);
    endtask

    task automatic t_signedness();
        mode_set(0, 0, 0, 0, 1, 0);
        fire(2'b11, 16'hFFFF, 16'hC000, 2'b00, 16'hFFFF, 16'hC000, 2'b00);
        chk("R4 lane0 ignores mixed", acc0, 40'h8000);
        chk("R4 lane1 mixed product", acc1, 40'hFFFFFF4000);
        chk("R4 R11 mixed dst", {8'h0, dst}, 40'hFFFF0001);
        mode_set(1, 1, 0, 0, 0, 0);
        fire(2'b11, 16'h00FF, 16'h0100, 2'b00, 16'hFFFF, 16'h0001, 2'b00);
        chk("R4 unsigned lane1 acc", acc1, 40'hFFFF);
        chk("R4 unsigned integer dst", {8'h0, dst}, 40'hFFFFFF00);
        mode_set(0, 1, 0, 0, 0, 0);
        fire(2'b01, 16'hFFFF, 16'hFFFF, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R4 unsigned fraction acc", acc0, 40'hFFFE0001);
        chk("R4 unsigned fraction extract", {24'h0, dst[15:0]}, 40'hFFFE);
        chk("R4 no overflow so far", {38'h0, ovf}, 40'h0);
    endtask

    task automatic t_scale();
        mode_set(0, 0, 0, 1, 0, 0);
        fire(2'b01, 16'h0100, 16'h00C0, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R10 acc not doubled", acc0, 40'h18000);
        chk("R10 fraction doubled", {24'h0, dst[15:0]}, 40'h3);
        mode_set(1, 0, 0, 1, 0, 0);
        fire(2'b01, 16'h0003, 16'h0005, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R10 integer doubled", {24'h0, dst[15:0]}, 40'h1E);
    endtask

    task automatic t_half_sat();
        mode_set(1, 0, 0, 0, 0, 0);
        fire(2'b01, 16'h0100, 16'h0100, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R9 signed clamp", {24'h0, dst[15:0]}, 40'h7FFF);
        chk("R9 lane0 flag only", {38'h0, ovf}, 40'h1);
        chk("R3 lane1 half kept", {24'h0, dst[31:16]}, 40'hFFFF);
        mode_set(1, 1, 0, 0, 0, 0);
        fire(2'b10, 16'h0, 16'h0, 2'b00, 16'hFFFF, 16'h0002, 2'b00);
        chk("R9 unsigned acc", acc1, 40'h1FFFE);
        chk("R9 unsigned clamp", {24'h0, dst[31:16]}, 40'hFFFF);
        chk("R9 both flags", {38'h0, ovf}, 40'h3);
        mode_set(1, 0, 0, 0, 0, 0);
        fire(2'b01, 16'h0003, 16'h0005, 2'b00, 16'h0, 16'h0, 2'b00);
        chk("R12 clean op result", {24'h0, dst[15:0]}, 40'hF);
        chk("R12 flags stay set", {38'h0, ovf}, 40'h3);
    endtask

    task automatic t_acc_sat();
        mode_set(0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 260; k++)
            fire(2'b11, 16'h8000, 16'h8000, (k == 0) ? 2'b00 : 2'b01,
                 16'h8000, 16'h8000, 2'b10);
        chk("R6 positive clamp", acc0, 40'h7FFFFFFFFF);
        chk("R6 negative clamp", acc1, 40'h8000000000);
        chk("R6 R9 clamped dst", {8'h0, dst}, 40'h80007FFF);
        chk("R6 flags set", {38'h0, ovf}, 40'h3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_frac_special();
        t_ops();
        t_round();
        t_int();
        t_signedness();
        t_scale();
        t_half_sat();
        t_acc_sat();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule